// File: doc/BRIEF.md
# Two-Wire Memory Transaction Sequencer

This block turns one transaction request into the ordered series of bus primitives that a separate two-wire bit engine carries out: START, STOP, byte write with acknowledge sampling, and byte read with a chosen acknowledge level. It handles three transaction kinds on a 7-bit device address. A probe checks whether a device answers. A write sends an internal address of 0 to 4 bytes and then a data burst. A read may first set the device's internal pointer and then reads a burst back.

Write bytes come in on a valid/ready stream, and read bytes leave on one. When the read consumer is not ready, the sequencer stops issuing read commands. The bus clock is therefore held and no byte is lost. At completion a one-cycle done pulse marks three status outputs as valid: a device no-response flag, an address-byte error flag, and a count of data bytes that were not acknowledged during a write.

A per-request choice selects how the pointer phase and the read phase are joined: either a bare repeated START, or a STOP followed by a START. A fold mask lets memories that keep extra address bits in the device address appear as several 256-byte devices.

Top module: `i2c_mem_seq`

## Requirements
- R1: After reset and between transactions, req_ready_o is 1, while eng_valid_o, rd_valid_o, wr_ready_o and done_o are 0.
- R2: A probe (req_op_i = 0) issues START, WRITE of {dev,0}, then STOP. absent_o is 1 exactly when that byte is NACKed.
- R3: A write (req_op_i = 1) whose device byte {dev,0} is NACKed issues STOP right away, sets absent_o, and consumes no write-stream byte.
- R4: The internal address is sent as req_alen_i bytes, most significant first. Values above 4 are treated as 4. A NACK on any address byte is followed by STOP, sets addr_err_o, and leaves the remaining phases out.
- R5: During a write, a NACK on a data byte does not stop the transfer. fail_cnt_o counts such NACKs, every one of the req_len_i bytes is still sent, and a STOP follows.
- R6: A read (req_op_i[1] = 1) with a nonzero address length first sends START, {dev,0} and the address bytes. The read phase then begins with START if cfg_rep_start_i = 1, or with STOP and then START if cfg_rep_start_i = 0, followed by {dev,1}.
- R7: A read with address length 0 skips the pointer phase and issues START and {dev,1} directly. A NACK on {dev,1} is followed by STOP and sets absent_o.
- R8: Each read command carries eng_nack_o = 0, except the last byte of the burst, which carries eng_nack_o = 1. STOP follows the last byte.
- R9: The device address on the bus is dev | ((addr >> 8*alen) & cfg_fold_mask_i). It is taken over the low 7 bits of the shifted address.
- R10: With req_len_i = 0, only the addressing phases are sent, and then STOP.
- R11: While a read byte waits on rd_valid_o with rd_ready_i low, no READ command is issued and rd_data_o holds. Bytes leave in bus order, and none is dropped.
- R12: Engine commands are cmd 0 START, 1 STOP, 2 WRITE (eng_wdata_o), 3 READ. A command stays valid and unchanged until eng_done_i, and at most one is outstanding at a time.
- R13: done_o is a single-cycle pulse. The status outputs hold their values until the next request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Transaction request valid |
| req_ready_o | output | 1 | Sequencer idle, request accepted |
| req_op_i | input | 2 | 0 probe, 1 write, 2 or 3 read |
| req_dev_i | input | 7 | Device address |
| req_addr_i | input | ADDR_BYTES*8 | Internal address |
| req_alen_i | input | 3 | Internal address length in bytes (0..4) |
| req_len_i | input | 8 | Data length in bytes (0..255) |
| cfg_rep_start_i | input | 1 | 1: repeated START before read phase; 0: STOP then START |
| cfg_fold_mask_i | input | 7 | Mask of address bits folded into the device address |
| wr_data_i | input | 8 | Write stream byte |
| wr_valid_i | input | 1 | Write stream valid |
| wr_ready_o | output | 1 | Write stream ready |
| rd_data_o | output | 8 | Read stream byte |
| rd_valid_o | output | 1 | Read stream valid |
| rd_ready_i | input | 1 | Read stream ready |
| eng_valid_o | output | 1 | Engine command valid |
| eng_cmd_o | output | 2 | Engine command code |
| eng_wdata_o | output | 8 | Byte to write |
| eng_nack_o | output | 1 | Acknowledge level for a read byte (1 = NACK) |
| eng_done_i | input | 1 | Engine command completed (one-cycle pulse) |
| eng_rdata_i | input | 8 | Byte read by engine |
| eng_rx_nack_i | input | 1 | Written byte was NACKed |
| done_o | output | 1 | Transaction finished pulse |
| absent_o | output | 1 | Device did not answer its address byte |
| addr_err_o | output | 1 | An internal address byte was NACKed |
| fail_cnt_o | output | 8 | Number of NACKed data bytes in a write |

## Verification
The hardest case to reach is a read-stream stall that falls between two read commands. The READ for the next byte must be held back while the previous byte is still waiting, and the last byte's NACK must still land on the correct command. The bench models the bit engine and a device, then throttles rd_ready_i so that it opens only one cycle in six during a multi-byte read. Each cycle it watches for a READ that is issued while a byte is still pending. It also places single NACKs on chosen byte positions of a transaction, which drives the abort paths and the data-NACK counting separately.

// File: rtl/i2c_mem_seq_pkg.sv
package i2c_mem_seq_pkg;
  typedef enum logic [1:0] {
    CMD_START = 2'd0,
    CMD_STOP  = 2'd1,
    CMD_WRITE = 2'd2,
    CMD_READ  = 2'd3
  } eng_cmd_e;

  typedef enum logic [3:0] {
    S_IDLE, S_START, S_DEVW, S_ADDR, S_MSTOP, S_RSTART, S_DEVR,
    S_WGET, S_WSEND, S_RCMD, S_RHOLD, S_STOP, S_DONE
  } seq_state_e;
endpackage

// File: rtl/i2c_seq_addr.sv
// Address byte selection and overflow-bit folding into the device address.
module i2c_seq_addr #(
  parameter int ADDR_BYTES = 4,
  localparam int AW = ADDR_BYTES * 8,
  localparam int IW = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1
) (
  input  logic [AW-1:0] addr_i,
  input  logic [2:0]    alen_i,
  input  logic [IW-1:0] idx_i,
  input  logic [6:0]    dev_i,
  input  logic [6:0]    mask_i,
  output logic [6:0]    dev_eff_o,
  output logic [7:0]    byte_o
);
  logic [7:0] bytes [ADDR_BYTES];
  logic [5:0] shamt;

  for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_byte
    assign bytes[g] = addr_i[g*8 +: 8];
  end

  assign shamt     = {alen_i, 3'b000};
  assign dev_eff_o = dev_i | (7'(addr_i >> shamt) & mask_i);
  assign byte_o    = bytes[idx_i];
endmodule

// File: rtl/i2c_seq_ctrl.sv
module i2c_seq_ctrl
  import i2c_mem_seq_pkg::*;
#(
  parameter int ADDR_BYTES = 4,
  localparam int AW = ADDR_BYTES * 8,
  localparam int IW = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic [1:0]    req_op_i,
  input  logic [6:0]    req_dev_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [2:0]    req_alen_i,
  input  logic [7:0]    req_len_i,
  input  logic          cfg_rep_start_i,
  input  logic [6:0]    cfg_fold_mask_i,
  input  logic [7:0]    wr_data_i,
  input  logic          wr_valid_i,
  output logic          wr_ready_o,
  output logic [7:0]    rd_data_o,
  output logic          rd_valid_o,
  input  logic          rd_ready_i,
  output logic          eng_valid_o,
  output eng_cmd_e      eng_cmd_o,
  output logic [7:0]    eng_wdata_o,
  output logic          eng_nack_o,
  input  logic          eng_done_i,
  input  logic [7:0]    eng_rdata_i,
  input  logic          eng_rx_nack_i,
  output logic          done_o,
  output logic          absent_o,
  output logic          addr_err_o,
  output logic [7:0]    fail_cnt_o,
  // to/from address unit
  output logic [AW-1:0] addr_q_o,
  output logic [2:0]    alen_q_o,
  output logic [IW-1:0] idx_q_o,
  output logic [6:0]    dev_q_o,
  output logic [6:0]    mask_q_o,
  input  logic [6:0]    dev_eff_i,
  input  logic [7:0]    addr_byte_i
);
  localparam logic [2:0] ALEN_MAX = 3'(ADDR_BYTES);

  seq_state_e st_q;
  logic [1:0]  op_q;
  logic        rep_q;
  logic [7:0]  rem_q, wbyte_q, rbyte_q, fail_q;
  logic        absent_q, aerr_q;
  logic        is_rd, is_probe;
  seq_state_e  after_addr;

  assign is_rd    = op_q[1];
  assign is_probe = (op_q == 2'b00);

  always_comb begin
    if (is_rd)             after_addr = rep_q ? S_RSTART : S_MSTOP;
    else if (rem_q == '0)  after_addr = S_STOP;
    else                   after_addr = S_WGET;
  end

  always_comb begin
    eng_valid_o = 1'b1;
    eng_cmd_o   = CMD_WRITE;
    eng_wdata_o = '0;
    eng_nack_o  = 1'b0;
    unique case (st_q)
      S_START, S_RSTART: eng_cmd_o = CMD_START;
      S_MSTOP, S_STOP:   eng_cmd_o = CMD_STOP;
      S_DEVW:            eng_wdata_o = {dev_eff_i, 1'b0};
      S_DEVR:            eng_wdata_o = {dev_eff_i, 1'b1};
      S_ADDR:            eng_wdata_o = addr_byte_i;
      S_WSEND:           eng_wdata_o = wbyte_q;
      S_RCMD: begin
        eng_cmd_o  = CMD_READ;
        eng_nack_o = (rem_q == 8'd1);  // last byte is NACKed
      end
      default:           eng_valid_o = 1'b0;
    endcase
  end

  assign req_ready_o = (st_q == S_IDLE);
  assign wr_ready_o  = (st_q == S_WGET);
  assign rd_valid_o  = (st_q == S_RHOLD);
  assign rd_data_o   = rbyte_q;
  assign done_o      = (st_q == S_DONE);
  assign absent_o    = absent_q;
  assign addr_err_o  = aerr_q;
  assign fail_cnt_o  = fail_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= S_IDLE;
      op_q     <= '0;
      rep_q    <= 1'b0;
      rem_q    <= '0;
      wbyte_q  <= '0;
      rbyte_q  <= '0;
      fail_q   <= '0;
      absent_q <= 1'b0;
      aerr_q   <= 1'b0;
      addr_q_o <= '0;
      alen_q_o <= '0;
      idx_q_o  <= '0;
      dev_q_o  <= '0;
      mask_q_o <= '0;
    end else begin
      unique case (st_q)
        S_IDLE: if (req_valid_i) begin
          op_q     <= req_op_i;
          dev_q_o  <= req_dev_i;
          addr_q_o <= req_addr_i;
          alen_q_o <= (req_alen_i > ALEN_MAX) ? ALEN_MAX : req_alen_i;
          rem_q    <= req_len_i;
          rep_q    <= cfg_rep_start_i;
          mask_q_o <= cfg_fold_mask_i;
          fail_q   <= '0;
          absent_q <= 1'b0;
          aerr_q   <= 1'b0;
          st_q     <= S_START;
        end
        S_START: if (eng_done_i)
          st_q <= (is_rd && alen_q_o == '0) ? S_DEVR : S_DEVW;
        S_DEVW: if (eng_done_i) begin
          if (eng_rx_nack_i) begin
            absent_q <= 1'b1;
            st_q     <= S_STOP;
          end else if (is_probe) begin
            st_q <= S_STOP;
          end else if (alen_q_o != '0) begin
            idx_q_o <= IW'(alen_q_o - 3'd1);
            st_q    <= S_ADDR;
          end else begin
            st_q <= after_addr;
          end
        end
        S_ADDR: if (eng_done_i) begin
          if (eng_rx_nack_i) begin
            aerr_q <= 1'b1;
            st_q   <= S_STOP;
          end else if (idx_q_o == '0) begin
            st_q <= after_addr;
          end else begin
            idx_q_o <= idx_q_o - 1'b1;
          end
        end
        S_MSTOP:  if (eng_done_i) st_q <= S_RSTART;
        S_RSTART: if (eng_done_i) st_q <= S_DEVR;
        S_DEVR: if (eng_done_i) begin
          if (eng_rx_nack_i) begin
            absent_q <= 1'b1;
            st_q     <= S_STOP;
          end else begin
            st_q <= (rem_q == '0) ? S_STOP : S_RCMD;
          end
        end
        S_WGET: if (wr_valid_i) begin
          wbyte_q <= wr_data_i;
          st_q    <= S_WSEND;
        end
        S_WSEND: if (eng_done_i) begin
          if (eng_rx_nack_i) fail_q <= fail_q + 8'd1;
          rem_q <= rem_q - 8'd1;
          st_q  <= (rem_q == 8'd1) ? S_STOP : S_WGET;
        end
        S_RCMD: if (eng_done_i) begin
          rbyte_q <= eng_rdata_i;
          st_q    <= S_RHOLD;
        end
        S_RHOLD: if (rd_ready_i) begin
          rem_q <= rem_q - 8'd1;
          st_q  <= (rem_q == 8'd1) ? S_STOP : S_RCMD;
        end
        S_STOP: if (eng_done_i) st_q <= S_DONE;
        S_DONE: st_q <= S_IDLE;
        default: st_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/i2c_mem_seq.sv
module i2c_mem_seq
  import i2c_mem_seq_pkg::*;
#(
  parameter int ADDR_BYTES = 4,
  localparam int AW = ADDR_BYTES * 8,
  localparam int IW = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic [1:0]    req_op_i,
  input  logic [6:0]    req_dev_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [2:0]    req_alen_i,
  input  logic [7:0]    req_len_i,
  input  logic          cfg_rep_start_i,
  input  logic [6:0]    cfg_fold_mask_i,
  input  logic [7:0]    wr_data_i,
  input  logic          wr_valid_i,
  output logic          wr_ready_o,
  output logic [7:0]    rd_data_o,
  output logic          rd_valid_o,
  input  logic          rd_ready_i,
  output logic          eng_valid_o,
  output logic [1:0]    eng_cmd_o,
  output logic [7:0]    eng_wdata_o,
  output logic          eng_nack_o,
  input  logic          eng_done_i,
  input  logic [7:0]    eng_rdata_i,
  input  logic          eng_rx_nack_i,
  output logic          done_o,
  output logic          absent_o,
  output logic          addr_err_o,
  output logic [7:0]    fail_cnt_o
);
  logic [AW-1:0] addr_q;
  logic [2:0]    alen_q;
  logic [IW-1:0] idx_q;
  logic [6:0]    dev_q, mask_q, dev_eff;
  logic [7:0]    addr_byte;
  eng_cmd_e      cmd;

  assign eng_cmd_o = cmd;

  i2c_seq_addr #(.ADDR_BYTES(ADDR_BYTES)) u_addr (
    .addr_i    (addr_q),
    .alen_i    (alen_q),
    .idx_i     (idx_q),
    .dev_i     (dev_q),
    .mask_i    (mask_q),
    .dev_eff_o (dev_eff),
    .byte_o    (addr_byte)
  );

  i2c_seq_ctrl #(.ADDR_BYTES(ADDR_BYTES)) u_ctrl (
    .clk_i, .rst_ni,
    .req_valid_i, .req_ready_o, .req_op_i, .req_dev_i, .req_addr_i,
    .req_alen_i, .req_len_i, .cfg_rep_start_i, .cfg_fold_mask_i,
    .wr_data_i, .wr_valid_i, .wr_ready_o,
    .rd_data_o, .rd_valid_o, .rd_ready_i,
    .eng_valid_o, .eng_cmd_o (cmd), .eng_wdata_o, .eng_nack_o,
    .eng_done_i, .eng_rdata_i, .eng_rx_nack_i,
    .done_o, .absent_o, .addr_err_o, .fail_cnt_o,
    .addr_q_o    (addr_q),
    .alen_q_o    (alen_q),
    .idx_q_o     (idx_q),
    .dev_q_o     (dev_q),
    .mask_q_o    (mask_q),
    .dev_eff_i   (dev_eff),
    .addr_byte_i (addr_byte)
  );
endmodule

// File: rtl/i2c_mem_seq_chk.sv
module i2c_mem_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       req_ready_o,
  input logic       wr_ready_o,
  input logic [7:0] rd_data_o,
  input logic       rd_valid_o,
  input logic       rd_ready_i,
  input logic       eng_valid_o,
  input logic [1:0] eng_cmd_o,
  input logic [7:0] eng_wdata_o,
  input logic       eng_nack_o,
  input logic       eng_done_i,
  input logic       done_o,
  input logic       absent_o,
  input logic       addr_err_o,
  input logic [7:0] fail_cnt_o
);
  assert_idle_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> !eng_valid_o && !rd_valid_o && !wr_ready_o && !done_o);

  assert_cmd_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_valid_o && !eng_done_i |=> eng_valid_o && $stable(eng_cmd_o)
      && $stable(eng_wdata_o) && $stable(eng_nack_o));

  assert_no_read_while_pending_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> !(eng_valid_o && eng_cmd_o == 2'd3));

  assert_rd_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o && !rd_ready_i |=> rd_valid_o && $stable(rd_data_o));

  assert_done_pulse_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_status_hold_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> $stable(absent_o) && $stable(addr_err_o) && $stable(fail_cnt_o));
endmodule

bind i2c_mem_seq i2c_mem_seq_chk u_chk (
  .clk_i, .rst_ni, .req_ready_o, .wr_ready_o, .rd_data_o, .rd_valid_o,
  .rd_ready_i, .eng_valid_o, .eng_cmd_o, .eng_wdata_o, .eng_nack_o,
  .eng_done_i, .done_o, .absent_o, .addr_err_o, .fail_cnt_o
);

// File: tb/test_i2c_mem_seq.sv
module test_i2c_mem_seq;
  localparam int AB = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic          req_valid_i = 1'b0, req_ready_o;
  logic [1:0]    req_op_i = '0;
  logic [6:0]    req_dev_i = '0;
  logic [AB*8-1:0] req_addr_i = '0;
  logic [2:0]    req_alen_i = '0;
  logic [7:0]    req_len_i = '0;
  logic          cfg_rep_start_i = 1'b0;
  logic [6:0]    cfg_fold_mask_i = '0;
  logic [7:0]    wr_data_i = '0;
  logic          wr_valid_i = 1'b1, wr_ready_o;
  logic [7:0]    rd_data_o;
  logic          rd_valid_o, rd_ready_i = 1'b1;
  logic          eng_valid_o, eng_nack_o;
  logic [1:0]    eng_cmd_o;
  logic [7:0]    eng_wdata_o;
  logic          eng_done_i = 1'b0, eng_rx_nack_i = 1'b0;
  logic [7:0]    eng_rdata_i = '0;
  logic          done_o, absent_o, addr_err_o;
  logic [7:0]    fail_cnt_o;

  i2c_mem_seq #(.ADDR_BYTES(AB)) i_i2c_mem_seq (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i, .req_ready_o, .req_op_i, .req_dev_i, .req_addr_i,
    .req_alen_i, .req_len_i, .cfg_rep_start_i, .cfg_fold_mask_i,
    .wr_data_i, .wr_valid_i, .wr_ready_o,
    .rd_data_o, .rd_valid_o, .rd_ready_i,
    .eng_valid_o, .eng_cmd_o, .eng_wdata_o, .eng_nack_o,
    .eng_done_i, .eng_rdata_i, .eng_rx_nack_i,
    .done_o, .absent_o, .addr_err_o, .fail_cnt_o
  );

  int n_run = 0, n_fail = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // ---------------- engine + device model ----------------
  int         eng_wait = 0, k_idx = 0, nack_k = -1, rd_ctr = 0;
  logic [6:0] present_dev = 7'h50;
  logic [1:0] log_c [64];
  logic [7:0] log_b [64];
  int         log_n = 0;

  always @(negedge clk) begin
    if (eng_done_i) begin
      eng_done_i = 1'b0;
    end else if (eng_valid_o) begin
      if (eng_wait < 1) eng_wait++;
      else begin
        logic [7:0] lb;
        eng_wait = 0;
        eng_done_i = 1'b1;
        eng_rx_nack_i = 1'b0;
        lb = 8'h00;
        case (eng_cmd_o)
          2'd0: k_idx = 0;
          2'd2: begin
            lb = eng_wdata_o;
            if (k_idx == 0) eng_rx_nack_i = (eng_wdata_o[7:1] != present_dev);
            else            eng_rx_nack_i = (k_idx == nack_k);
            k_idx++;
          end
          2'd3: begin
            eng_rdata_i = 8'hA0 + 8'(rd_ctr);
            rd_ctr++;
            lb = {7'b0, eng_nack_o};
          end
          default: ;
        endcase
        if (log_n < 64) begin
          log_c[log_n] = eng_cmd_o;
          log_b[log_n] = lb;
        end
        log_n++;
      end
    end
  end

  // ---------------- streams ----------------
  logic [7:0] wr_buf [16];
  logic [7:0] rd_got [16];
  int   wr_idx = 0, rd_n = 0, stall_ctr = 0, viol = 0;
  bit   wr_adv = 0, stall_en = 0;

  always @(negedge clk) begin
    if (wr_adv) wr_idx++;
    wr_data_i = wr_buf[wr_idx % 16];
    wr_adv = wr_ready_o && wr_valid_i;
    stall_ctr++;
    rd_ready_i = !stall_en || (stall_ctr % 6 == 0);
    if (rd_valid_o && rd_ready_i) begin
      rd_got[rd_n % 16] = rd_data_o;
      rd_n++;
    end
    if (rd_valid_o && eng_valid_o && eng_cmd_o == 2'd3) viol++;
  end

  // ---------------- expected log ----------------
  logic [1:0] ex_c [64];
  logic [7:0] ex_b [64];
  int ex_n = 0;

  task automatic ex_add(input logic [1:0] c, input logic [7:0] b);
    ex_c[ex_n] = c; ex_b[ex_n] = b; ex_n++;
  endtask

  task automatic chk_log(input string req);
    int bad = -1;
    if (log_n == ex_n)
      for (int i = 0; i < ex_n; i++)
        if (bad < 0 && (log_c[i] != ex_c[i] || log_b[i] != ex_b[i])) bad = i;
    if (log_n != ex_n) chk(0, req, "command count", log_n, ex_n);
    else if (bad >= 0)
      chk(0, req, $sformatf("command %0d {cmd,byte}", bad),
          {log_c[bad], log_b[bad]}, {ex_c[bad], ex_b[bad]});
    else chk(1, req, "command log", 0, 0);
  endtask

  task automatic prep(input logic [6:0] dev_ok, input int nk);
    @(posedge clk); #1;
    log_n = 0; ex_n = 0; rd_ctr = 0; rd_n = 0; wr_idx = 0; viol = 0;
    present_dev = dev_ok; nack_k = nk;
    for (int i = 0; i < 16; i++) wr_buf[i] = 8'h11 * 8'(i + 1);
  endtask

  task automatic run(input logic [1:0] op, input logic [6:0] dev,
                     input logic [31:0] addr, input logic [2:0] alen,
                     input logic [7:0] len, input logic rep, input logic [6:0] mask);
    int t = 0;
    @(negedge clk);
    req_op_i = op; req_dev_i = dev; req_addr_i = addr; req_alen_i = alen;
    req_len_i = len; cfg_rep_start_i = rep; cfg_fold_mask_i = mask;
    req_valid_i = 1'b1;
    @(negedge clk);
    req_valid_i = 1'b0;
    while (!done_o && t < 5000) begin
      @(negedge clk);
      t++;
    end
    chk(done_o, "R13", "done pulse seen", done_o, 1);
  endtask

  task automatic end_txn();
    @(negedge clk);
    chk(!done_o && req_ready_o, "R13", "done single cycle, idle again",
        {done_o, req_ready_o}, 2'b01);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    chk(req_ready_o && !eng_valid_o && !rd_valid_o && !wr_ready_o && !done_o,
        "R1", "idle outputs", {req_ready_o, eng_valid_o, rd_valid_o, wr_ready_o, done_o},
        5'b10000);
  endtask

  task automatic t_probe();
    prep(7'h50, -1);
    run(2'd0, 7'h50, 0, 0, 0, 1, 0);
    ex_add(0, 0); ex_add(2, 8'hA0); ex_add(1, 0);
    chk_log("R2");
    chk(!absent_o, "R2", "present probe absent flag", absent_o, 0);
    end_txn();
    prep(7'h50, -1);
    run(2'd0, 7'h51, 0, 0, 0, 1, 0);
    ex_add(0, 0); ex_add(2, 8'hA2); ex_add(1, 0);
    chk_log("R2");
    chk(absent_o, "R2", "missing probe absent flag", absent_o, 1);
    end_txn();
  endtask

  task automatic t_write_absent();
    prep(7'h50, -1);
    run(2'd1, 7'h33, 32'h12, 1, 3, 1, 0);
    ex_add(0, 0); ex_add(2, 8'h66); ex_add(1, 0);
    chk_log("R3");
    chk(absent_o && !addr_err_o, "R3", "absent flags", {absent_o, addr_err_o}, 2'b10);
    chk(wr_idx == 0, "R3", "write bytes consumed", wr_idx, 0);
    end_txn();
  endtask

  task automatic t_write_ok();
    prep(7'h50, -1);
    run(2'd1, 7'h50, 32'h1234, 2, 3, 1, 0);
    ex_add(0, 0); ex_add(2, 8'hA0); ex_add(2, 8'h12); ex_add(2, 8'h34);
    ex_add(2, 8'h11); ex_add(2, 8'h22); ex_add(2, 8'h33); ex_add(1, 0);
    chk_log("R4");
    chk(fail_cnt_o == 0 && !addr_err_o && !absent_o, "R4", "clean status",
        {absent_o, addr_err_o, fail_cnt_o}, 0);
    end_txn();
  endtask

  task automatic t_write_data_nack();
    prep(7'h50, 4);  // byte index 4: second data byte
    run(2'd1, 7'h50, 32'h1234, 2, 3, 1, 0);
    ex_add(0, 0); ex_add(2, 8'hA0); ex_add(2, 8'h12); ex_add(2, 8'h34);
    ex_add(2, 8'h11); ex_add(2, 8'h22); ex_add(2, 8'h33); ex_add(1, 0);
    chk_log("R5");
    chk(fail_cnt_o == 1, "R5", "fail count", fail_cnt_o, 1);
    chk(wr_idx == 3, "R5", "bytes consumed", wr_idx, 3);
    end_txn();
  endtask

  task automatic t_addr_nack();
    prep(7'h50, 1);
    run(2'd1, 7'h50, 32'h00AB_CDEF, 3, 2, 1, 0);
    ex_add(0, 0); ex_add(2, 8'hA0); ex_add(2, 8'hAB); ex_add(1, 0);
    chk_log("R4");
    chk(addr_err_o && !absent_o, "R4", "address error flags", {addr_err_o, absent_o}, 2'b10);
    chk(wr_idx == 0, "R4", "write bytes consumed", wr_idx, 0);
    end_txn();
  endtask

  task automatic t_read_ptr(input logic rep);
    prep(7'h50, -1);
    run(2'd2, 7'h50, 32'h05, 1, 3, rep, 0);
    ex_add(0, 0); ex_add(2, 8'hA0); ex_add(2, 8'h05);
    if (!rep) ex_add(1, 0);
    ex_add(0, 0); ex_add(2, 8'hA1);
    ex_add(3, 0); ex_add(3, 0); ex_add(3, 1); ex_add(1, 0);
    chk_log(rep ? "R6 repeated start" : "R6 stop-start");
    chk(rd_n == 3 && rd_got[0] == 8'hA0 && rd_got[2] == 8'hA2, "R8", "read bytes",
        {8'(rd_n), rd_got[0], rd_got[2]}, {8'd3, 8'hA0, 8'hA2});
    end_txn();
  endtask

  task automatic t_read_direct();
    prep(7'h50, -1);
    run(2'd3, 7'h50, 32'hFF, 0, 2, 0, 0);
    ex_add(0, 0); ex_add(2, 8'hA1); ex_add(3, 0); ex_add(3, 1); ex_add(1, 0);
    chk_log("R7");
    end_txn();
    prep(7'h50, -1);
    run(2'd2, 7'h22, 0, 0, 2, 0, 0);
    ex_add(0, 0); ex_add(2, 8'h45); ex_add(1, 0);
    chk_log("R7");
    chk(absent_o && rd_n == 0, "R7", "absent on read, no bytes", {absent_o, 8'(rd_n)}, 9'h100);
    end_txn();
  endtask

  task automatic t_fold_len0();
    prep(7'h52, -1);
    run(2'd1, 7'h50, 32'h0000_02FF, 1, 0, 1, 7'h07);
    ex_add(0, 0); ex_add(2, 8'hA4); ex_add(2, 8'hFF); ex_add(1, 0);
    chk_log("R9 R10");
    chk(!absent_o && wr_idx == 0, "R10", "no data consumed", wr_idx, 0);
    end_txn();
  endtask

  task automatic t_read_stall();
    prep(7'h50, -1);
    stall_en = 1;
    run(2'd2, 7'h50, 0, 0, 4, 1, 0);
    stall_en = 0;
    ex_add(0, 0); ex_add(2, 8'hA1);
    ex_add(3, 0); ex_add(3, 0); ex_add(3, 0); ex_add(3, 1); ex_add(1, 0);
    chk_log("R11");
    chk(viol == 0, "R11", "READ issued while byte pending", viol, 0);
    chk(rd_n == 4, "R11", "bytes delivered", rd_n, 4);
    for (int i = 0; i < 4; i++)
      chk(rd_got[i] == 8'hA0 + 8'(i), "R11", $sformatf("byte %0d order", i),
          rd_got[i], 8'hA0 + 8'(i));
    end_txn();
  endtask

  // R12 handshake behaviour is exercised by every scenario through the engine model
  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_probe();
    t_write_absent();
    t_write_ok();
    t_write_data_nack();
    t_addr_nack();
    t_read_ptr(1'b1);
    t_read_ptr(1'b0);
    t_read_direct();
    t_fold_len0();
    t_read_stall();
    @(negedge clk);
    t_reset();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule